// File: doc/BRIEF.md
# Timer Event Capture Unit

This block timestamps external events against a free-running timer count that is supplied from outside. The trigger comes from either a digital pin or a comparator output. The selected signal passes through a two-stage synchronizer and an optional digital filter that needs four agreeing samples. It then reaches an edge detector set to rising or falling. On every qualified edge the block stores the current timer count in a 16-bit capture register and raises a capture flag.

Software reaches the capture register through a byte-wide register port with one shared high-byte holding register, so that 16-bit values are read and written atomically. The register can be written only while the timer runs in a mode that uses it as the counter TOP value. In that mode no captures are taken. The event path has no flow control: the block takes no back-pressure and drops nothing, and every qualified edge overwrites the register. The register port is a plain single-cycle strobe interface with no valid/ready handshake.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset the capture register reads 0, the capture flag is 0 and `bus_rdata` is 0.
- R2: With the filter off, a change of the selected trigger that matches the edge polarity (`edge_rise`=1 rising, 0 falling) stores `timer_count` as sampled at the third rising clock edge after the change. The flag is set at that same edge and not before.
- R3: With the filter on (`filt_en`=1), the same capture happens at the seventh rising clock edge after the change, four clocks later than in R2. A new level held for fewer than four clock cycles produces no capture.
- R4: `src_sel`=0 selects `pin_in` and `src_sel`=1 selects `cmp_in`; changes on the unselected input are ignored. Switching `src_sel` between inputs at different levels counts as an edge on the trigger and may cause a capture.
- R5: While `top_mode`=1 no capture is taken and the flag is not set by trigger activity.
- R6: A write with `bus_hi`=1 loads the holding register. A later write with `bus_hi`=0 stores {holding, `bus_wdata`} into the capture register, but only while `top_mode`=1. Otherwise the capture register is left unchanged.
- R7: A read with `bus_hi`=0 returns the low byte of the capture register and copies its high byte into the holding register. A read with `bus_hi`=1 returns the holding register, even if a capture occurred between the two reads.
- R8: A `flag_clr` pulse clears the flag. If a capture and `flag_clr` fall in the same cycle, the flag ends set.
- R9: A new capture overwrites an unread earlier one; only the latest value is kept.
- R10: An edge of the opposite polarity causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External capture pin |
| cmp_in | input | 1 | Comparator output trigger |
| src_sel | input | 1 | Trigger select: 0 pin, 1 comparator |
| filt_en | input | 1 | Enables the four-sample noise filter |
| edge_rise | input | 1 | 1 captures on rising edges, 0 on falling edges |
| top_mode | input | 1 | Capture register serves as counter TOP |
| timer_count | input | 16 | Free-running timer value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_hi | input | 1 | Byte select: 1 high, 0 low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| flag_clr | input | 1 | Clears the capture flag |
| cap_flag | output | 1 | Capture flag |
| cap_value | output | 16 | Current capture register contents |

## Verification
The capture path is swept over every combination of trigger source, polarity and filter setting. Each combination checks the exact capture edge one cycle early and on time, so latency slips of one cycle in either direction are caught. A pulse-width sweep from one to six cycles with the filter on separates a four-sample filter from a three- or five-sample one. A one-cycle pulse with the filter off shows that the filter is truly bypassed. Separate sequences cover source switching, TOP mode, the byte-port ordering with a capture landing between two reads, and a clear that collides with a capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    TRIG_PIN = 1'b0,
    TRIG_CMP = 1'b1
  } trig_src_e;

  function automatic logic pick_trig(input trig_src_e sel, input logic pin, input logic cmp);
    return (sel == TRIG_CMP) ? cmp : pin;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= din;
      for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/cap_noise_filter.sv
module cap_noise_filter #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int HIST = TAPS - 1;

  logic [HIST-1:0] hist_q;
  logic            agree;
  logic            out_q;

  always_comb begin
    agree = 1'b1;
    for (int i = 0; i < HIST; i++) agree = agree & (hist_q[i] == din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q[0] <= din;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
      if (agree) out_q <= din;
    end
  end

  assign dout = out_q;

  p_filt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !agree |=> $stable(out_q));
  p_filt_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    agree |=> (out_q == $past(din)));
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  input  logic enable,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign pulse = enable & (rise_sel ? (din & ~prev_q) : (~din & prev_q));

  p_no_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && rise_sel) |=> !(pulse && rise_sel));
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pulse);
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              cmp_in,
  input  logic              src_sel,
  input  logic              filt_en,
  input  logic              edge_rise,
  input  logic              top_mode,
  input  logic [WORD_W-1:0] timer_count,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_hi,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              flag_clr,
  output logic              cap_flag,
  output logic [WORD_W-1:0] cap_value
);
  logic trig_raw, trig_s, trig_f, det_in, cap_event;
  logic wr_lo, wr_hi, rd_lo;
  logic [WORD_W-1:0] cap_q;
  logic [BYTE_W-1:0] hold_q;
  logic              flag_q;

  assign trig_raw = pick_trig(trig_src_e'(src_sel), pin_in, cmp_in);

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_raw), .dout(trig_s)
  );

  generate
    if (FILT_TAPS > 1) begin : g_filt
      cap_noise_filter #(.TAPS(FILT_TAPS)) u_filt (
        .clk(clk), .rst_n(rst_n), .din(trig_s), .dout(trig_f)
      );
    end else begin : g_nofilt
      assign trig_f = trig_s;
    end
  endgenerate

  assign det_in = filt_en ? trig_f : trig_s;

  cap_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .din(det_in), .rise_sel(edge_rise),
    .enable(~top_mode), .pulse(cap_event)
  );

  assign wr_lo = bus_wr & ~bus_hi;
  assign wr_hi = bus_wr &  bus_hi;
  assign rd_lo = bus_rd & ~bus_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_event)            cap_q <= timer_count;
      else if (wr_lo && top_mode) cap_q <= {hold_q, bus_wdata};

      if (wr_hi)      hold_q <= bus_wdata;
      else if (rd_lo) hold_q <= cap_q[WORD_W-1:BYTE_W];

      if (cap_event)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) bus_rdata = bus_hi ? hold_q : cap_q[BYTE_W-1:0];
  end

  assign cap_flag  = flag_q;
  assign cap_value = cap_q;

  p_capture_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> (cap_q == $past(timer_count)));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> flag_q);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_event) |=> !flag_q);
  p_top_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mode && !wr_lo) |=> $stable(cap_q));
  p_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!top_mode && !cap_event) |=> $stable(cap_q));
endmodule

// File: tb/tmr_capture_unit_test.sv
module tmr_capture_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 0, cmp_in = 0, src_sel = 0, filt_en = 0, edge_rise = 1, top_mode = 0;
  logic bus_rd = 0, bus_wr = 0, bus_hi = 0, flag_clr = 0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cap_flag;
  logic [15:0] cap_value;
  logic [15:0] cnt = '0;
  logic [15:0] ofs = '0;
  logic [15:0] timer_count;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;
  assign timer_count = cnt + ofs;

  tmr_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in), .src_sel(src_sel),
    .filt_en(filt_en), .edge_rise(edge_rise), .top_mode(top_mode),
    .timer_count(timer_count), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_hi(bus_hi),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_clr(flag_clr),
    .cap_flag(cap_flag), .cap_value(cap_value)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_trig(input bit s, input bit v);
    if (s) cmp_in = v; else pin_in = v;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic rd(input bit hi, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_hi = hi; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_hi = 0;
  endtask

  task automatic wr(input bit hi, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_hi = hi; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_hi = 0;
  endtask

  // one polarity/source/filter case, checked one cycle early and on time
  task automatic edge_case(input bit s, input bit rise, input bit filt);
    logic [15:0] c;
    int lat;
    lat = filt ? 7 : 3;
    @(negedge clk);
    src_sel = s; edge_rise = rise; filt_en = filt;
    pin_in = ~rise; cmp_in = ~rise;
    cyc(12);
    clear_flag();
    @(negedge clk);
    c = timer_count;
    drive_trig(s, rise);
    cyc(lat - 1);
    chk(cap_flag == 0, "R2/R3 early flag", cap_flag, 0);
    cyc(1);
    chk(cap_flag == 1, "R2/R3 flag on time", cap_flag, 1);
    chk(cap_value == c + 16'(lat - 1), filt ? "R3 filtered value" : "R2 value",
        cap_value, c + 16'(lat - 1));
    clear_flag();
    drive_trig(~s, rise);
    cyc(12);
    chk(cap_flag == 0, "R4 unselected input ignored", cap_flag, 0);
    drive_trig(s, ~rise);
    cyc(12);
    chk(cap_flag == 0, "R10 opposite edge", cap_flag, 0);
    chk(cap_value == c + 16'(lat - 1), "R9/R10 value kept", cap_value, c + 16'(lat - 1));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c, a;
    cyc(3);
    rst_n = 1;
    #1;
    chk(cap_value == 0, "R1 capture reset", cap_value, 0);
    chk(cap_flag == 0, "R1 flag reset", cap_flag, 0);
    chk(bus_rdata == 0, "R1 rdata idle", bus_rdata, 0);
    rd(0, d);
    chk(d == 0, "R1 low byte reset", d, 0);

    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int f = 0; f < 2; f++)
          edge_case(s[0], r[0], f[0]);

    // R3 pulse-width sweep with filter on, plus unfiltered short pulse
    for (int w = 1; w <= 6; w++) begin
      @(negedge clk); src_sel = 0; edge_rise = 1; filt_en = 1; pin_in = 0;
      cyc(12); clear_flag();
      @(negedge clk); c = timer_count; pin_in = 1;
      cyc(w); pin_in = 0;
      cyc(12);
      chk(cap_flag == (w >= 4), "R3 pulse width", cap_flag, int'(w >= 4));
      if (w >= 4) chk(cap_value == c + 16'd6, "R3 pulse value", cap_value, c + 16'd6);
    end
    @(negedge clk); filt_en = 0; cyc(12); clear_flag();
    @(negedge clk); c = timer_count; pin_in = 1;
    cyc(1); pin_in = 0; cyc(12);
    chk(cap_flag == 1, "R3 filter bypassed", cap_flag, 1);
    chk(cap_value == c + 16'd2, "R2 short pulse value", cap_value, c + 16'd2);

    // R4 source switch
    @(negedge clk); src_sel = 0; pin_in = 0; cmp_in = 1; edge_rise = 1;
    cyc(12); clear_flag();
    @(negedge clk); c = timer_count; src_sel = 1;
    cyc(3);
    chk(cap_flag == 1, "R4 switch captures", cap_flag, 1);
    chk(cap_value == c + 16'd2, "R4 switch value", cap_value, c + 16'd2);
    clear_flag();
    chk(cap_flag == 0, "R8 clear", cap_flag, 0);

    // R8 collision: clear lands in the capture cycle
    @(negedge clk); cmp_in = 0; cyc(12); clear_flag();
    @(negedge clk); c = timer_count; cmp_in = 1;
    cyc(2); flag_clr = 1;
    cyc(1); flag_clr = 0;
    chk(cap_flag == 1, "R8 capture wins", cap_flag, 1);

    // R9 overwrite
    @(negedge clk); cmp_in = 0; cyc(6);
    @(negedge clk); c = timer_count; cmp_in = 1; cyc(10);
    chk(cap_value == c + 16'd2, "R9 overwrite", cap_value, c + 16'd2);

    // R7 atomic read across an intervening capture
    @(negedge clk); cmp_in = 0; ofs = 16'h1200; cyc(8);
    @(negedge clk); a = timer_count + 16'd2; cmp_in = 1; cyc(8);
    rd(0, d);
    chk(d == a[7:0], "R7 low read", d, a[7:0]);
    @(negedge clk); cmp_in = 0; ofs = 16'h7700; cyc(8);
    @(negedge clk); c = timer_count + 16'd2; cmp_in = 1; cyc(8);
    chk(cap_value == c, "R7 second capture", cap_value, c);
    rd(1, d);
    chk(d == a[15:8], "R7 high from holding", d, a[15:8]);

    // R5 / R6 TOP mode
    @(negedge clk); top_mode = 1; cmp_in = 0; cyc(8); clear_flag();
    a = cap_value;
    cmp_in = 1; cyc(8); cmp_in = 0; cyc(8);
    chk(cap_flag == 0, "R5 no flag in top mode", cap_flag, 0);
    chk(cap_value == a, "R5 no capture in top mode", cap_value, a);
    wr(1, 8'hAB); wr(0, 8'hCD);
    chk(cap_value == 16'hABCD, "R6 write in top mode", cap_value, 16'hABCD);
    rd(0, d);
    chk(d == 8'hCD, "R6 read back low", d, 8'hCD);
    @(negedge clk); top_mode = 0;
    wr(1, 8'h12); wr(0, 8'h34);
    chk(cap_value == 16'hABCD, "R6 write ignored", cap_value, 16'hABCD);
    rd(1, d);
    chk(d == 8'h12, "R6 holding loaded", d, 8'h12);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule